// File: doc/BRIEF.md
# Transmit Submission Queue Consumer

This block drains a circular ring of one-word submission entries held in shared memory. The host fills a slot to hand the device a chain of buffer descriptors for one connection. Ownership of each slot passes through a single flag bit inside the entry, so there are no head or tail registers. The device keeps a read pointer and fetches the entry at that slot. When the flag is set, the block offers the descriptor pointer and the connection index to the connection scheduler. Once the scheduler accepts, the block writes the entry back with only the flag cleared, then moves to the next slot.

When the fetched slot is empty, the pointer stays where it is. The block waits for a programmable idle interval and then reads the same slot again. Only the ring base address, the ring size (as a power of two) and the idle interval are configured. Walking the descriptor chain and cutting cells are left to other blocks.

Top module: `txq_consumer`

## Requirements
- R1: An entry is a 32-bit word. Bit 0 is the ownership flag (1 = submitted, 0 = empty), bits 15:1 hold the connection index, and bits 31:16 hold the descriptor pointer. After reset the read pointer is slot 0, so the first read request goes to `cfg_base`, and no link request is made during reset.
- R2: Every memory request addresses `cfg_base + slot`. Only one request is in flight at a time, and no new request is made while read data is awaited. A request holds its address and direction until `mem_gnt` is high in the same cycle.
- R3: When read data with the flag set returns in cycle t, `link_req` is high in cycle t+1. It carries bits 31:16 on `link_bd_ptr` and bits 15:1 on `link_conn`.
- R4: While `link_busy` is high, `link_req` stays high with stable fields, no memory request is made and the pointer does not move. The request is accepted in the first cycle where `link_busy` is low.
- R5: If the link is accepted in cycle t, a write to the same slot starts in cycle t+1. The written word equals the read word with bit 0 cleared, so all other fields are unchanged.
- R6: The pointer advances only when the clearing write is granted. If that grant is in cycle t, the read of the next slot starts in cycle t+1.
- R7: After the last slot, 2^n - 1, the pointer returns to slot 0.
- R8: When read data with the flag clear returns in cycle t, no link request and no write follow. The pointer is held, and the same slot is read again starting in cycle t + `cfg_idle_gap` + 2.
- R9: `cfg_size_log2` is clamped to the range 6..14. Smaller values give a 64-entry ring and larger values give a 16384-entry ring.
- R10: Submitted entries are linked in slot order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Word address of ring slot 0 |
| cfg_size_log2 | input | 5 | Log2 of ring entries (clamped 6..14) |
| cfg_idle_gap | input | 16 | Idle cycles before re-reading an empty slot |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| link_req | output | 1 | Link request to the scheduler |
| link_conn | output | 15 | Connection index |
| link_bd_ptr | output | 16 | Descriptor chain pointer |
| link_busy | input | 1 | Scheduler refuses this cycle |

## Verification
The results are due at fixed distances after the input that triggers them:
- A link request appears one cycle after non-empty read data.
- The clearing write appears one cycle after link acceptance.
- The next read appears one cycle after the write grant.
- An empty slot is re-read `cfg_idle_gap` + 2 cycles after its data returned.

The bench keeps its own phase model of these distances, advanced by the grant, busy and read-data values it drives itself. It compares every output on every cycle at the falling edge, so an early or late event shows up as a mismatch in that cycle. Memory grants, read latency and scheduler refusals are varied by a pseudo-random sequence. Three configurations are run: 64 slots, 128 slots, and a clamped size value.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int WORD_W   = 32;
  localparam int FLAG_POS = 0;
  localparam int CONN_LSB = 1;
  localparam int CONN_W   = 15;
  localparam int BDP_LSB  = 16;
  localparam int BDP_W    = 16;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_RWAIT = 3'd1,
    ST_LINK  = 3'd2,
    ST_CLEAR = 3'd3,
    ST_GAP   = 3'd4
  } txq_state_e;

  // clamp the configured ring size exponent into [lo, hi]
  function automatic logic [4:0] clamp_log2(logic [4:0] v, int lo, int hi);
    if (int'(v) < lo) return 5'(lo);
    if (int'(v) > hi) return 5'(hi);
    return v;
  endfunction

  function automatic int unsigned ring_mask(int unsigned lg);
    return (32'd1 << lg) - 32'd1;
  endfunction

  function automatic int unsigned ring_next(int unsigned cur, int unsigned lg);
    return (cur + 32'd1) & ring_mask(lg);
  endfunction

  function automatic logic entry_owned(logic [WORD_W-1:0] w);
    return w[FLAG_POS];
  endfunction

  function automatic logic [CONN_W-1:0] entry_conn(logic [WORD_W-1:0] w);
    return w[CONN_LSB +: CONN_W];
  endfunction

  function automatic logic [BDP_W-1:0] entry_bdp(logic [WORD_W-1:0] w);
    return w[BDP_LSB +: BDP_W];
  endfunction

  // hand the slot back: only the ownership flag changes
  function automatic logic [WORD_W-1:0] entry_release(logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[FLAG_POS] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/txq_rdptr.sv
module txq_rdptr
  import txq_pkg::*;
#(
  parameter int PTR_W    = 14,
  parameter int MIN_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cfg_size_log2,
  input  logic             adv,
  output logic [PTR_W-1:0] slot
);

  logic [4:0] lg;
  logic       at_last;

  assign lg      = clamp_log2(cfg_size_log2, MIN_LOG2, PTR_W);
  assign at_last = (32'(slot) == ring_mask(32'(lg)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else if (adv) slot <= PTR_W'(ring_next(32'(slot), 32'(lg)));
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(slot));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_last) |=> (slot == '0));
  p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(slot) >> lg) == 32'd0);

endmodule

// File: rtl/txq_idle_timer.sv
module txq_idle_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             tick,
  output logic             done
);

  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt != '0));

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              link_busy,
  input  logic              gap_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              link_req,
  output logic [CONN_W-1:0] link_conn,
  output logic [BDP_W-1:0]  link_bd_ptr,
  output logic              gap_load,
  output logic              gap_tick,
  output logic              adv_slot,
  output logic              ev_link_ok,
  output logic              ev_empty_seen
);

  txq_state_e        state;
  logic [WORD_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_READ;
      held  <= '0;
    end else begin
      case (state)
        ST_READ:  if (mem_gnt) state <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid) begin
          held  <= mem_rdata;
          state <= entry_owned(mem_rdata) ? ST_LINK : ST_GAP;
        end
        ST_LINK:  if (!link_busy) state <= ST_CLEAR;
        ST_CLEAR: if (mem_gnt) state <= ST_READ;
        ST_GAP:   if (gap_done) state <= ST_READ;
        default:  state <= ST_READ;
      endcase
    end
  end

  always_comb begin
    mem_req       = (state == ST_READ) || (state == ST_CLEAR);
    mem_we        = (state == ST_CLEAR);
    mem_wdata     = entry_release(held);
    link_req      = (state == ST_LINK);
    link_conn     = entry_conn(held);
    link_bd_ptr   = entry_bdp(held);
    ev_empty_seen = (state == ST_RWAIT) && mem_rvalid && !entry_owned(mem_rdata);
    gap_load      = ev_empty_seen;
    gap_tick      = (state == ST_GAP) && !gap_done;
    adv_slot      = (state == ST_CLEAR) && mem_gnt;
    ev_link_ok    = link_req && !link_busy;
  end

  p_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && link_req));
  p_link_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && link_busy) |=> (link_req && $stable(link_conn) && $stable(link_bd_ptr)));
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we)));
  p_clear_after_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && mem_we) |-> $past(ev_link_ok));
  p_empty_no_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_empty_seen |=> !link_req);

endmodule

// File: rtl/txq_consumer.sv
module txq_consumer
  import txq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GAP_W    = 16,
  parameter int PTR_W    = 14,
  parameter int MIN_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [4:0]        cfg_size_log2,
  input  logic [GAP_W-1:0]  cfg_idle_gap,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              link_req,
  output logic [CONN_W-1:0] link_conn,
  output logic [BDP_W-1:0]  link_bd_ptr,
  input  logic              link_busy
);

  logic [PTR_W-1:0] slot;
  logic             gap_load;
  logic             gap_tick;
  logic             gap_done;
  logic             adv_slot;
  logic             ev_link_ok;
  logic             ev_empty_seen;

  txq_rdptr #(.PTR_W(PTR_W), .MIN_LOG2(MIN_LOG2)) u_ptr (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_size_log2 (cfg_size_log2),
    .adv           (adv_slot),
    .slot          (slot)
  );

  txq_idle_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (cfg_idle_gap),
    .tick     (gap_tick),
    .done     (gap_done)
  );

  txq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_gnt       (mem_gnt),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .link_busy     (link_busy),
    .gap_done      (gap_done),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_wdata     (mem_wdata),
    .link_req      (link_req),
    .link_conn     (link_conn),
    .link_bd_ptr   (link_bd_ptr),
    .gap_load      (gap_load),
    .gap_tick      (gap_tick),
    .adv_slot      (adv_slot),
    .ev_link_ok    (ev_link_ok),
    .ev_empty_seen (ev_empty_seen)
  );

  assign mem_addr = cfg_base + ADDR_W'(slot);

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> $stable(mem_addr));
  p_no_adv_on_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |=> $stable(slot));

endmodule

// File: tb/txq_consumer_test.sv
module txq_consumer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_size_log2 = 5'd6;
  logic [15:0] cfg_idle_gap = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        link_req;
  logic [14:0] link_conn;
  logic [15:0] link_bd_ptr;
  logic        link_busy = 1'b0;

  txq_consumer uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
    .cfg_idle_gap(cfg_idle_gap), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .link_req(link_req),
    .link_conn(link_conn), .link_bd_ptr(link_bd_ptr), .link_busy(link_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int phase = 0, mptr = 0, qsize = 64, gap_left = 0, ret_at = 0;
  int host_left = 0, host_slot = 0, sub_n = 0, links = 0;
  bit busy_mode = 0;
  logic [31:0] cap = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_q[$];
  logic [31:0] mem [0:16383];

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cyc=%0d act=%0h exp=%0h", req, what, cyc, act, exp);
    end
  endtask

  // reference model: phases 0 read, 1 await data, 2 link, 3 clear, 4 idle gap
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    if (!rst_n) begin
      phase = 0; mptr = 0; mem_gnt = 1'b0; link_busy = 1'b0;
      chk("R1", "link_req in reset", link_req, 0);
    end else begin
      mem_gnt   = lfsr[0] | lfsr[3];
      link_busy = busy_mode & (lfsr[5] | lfsr[9]);
      case (phase)
        0: begin
          chk("R2", "read req", mem_req, 1);
          chk("R2", "read dir", mem_we, 0);
          chk("R2", "read addr", mem_addr, cfg_base + 32'(mptr));
          chk("R4", "no link while reading", link_req, 0);
          if (mem_gnt) begin phase = 1; ret_at = cyc + 1 + int'(lfsr[2]); end
        end
        1: begin
          chk("R2", "no req in flight", mem_req, 0);
          chk("R2", "no link awaiting data", link_req, 0);
          if (cyc == ret_at) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[mptr];
            cap = mem[mptr];
            if (cap[0]) phase = 2;
            else begin phase = 4; gap_left = int'(cfg_idle_gap) + 1; end
          end
        end
        2: begin
          chk("R3", "link_req", link_req, 1);
          chk("R4", "no mem while linking", mem_req, 0);
          chk("R3", "link_conn", link_conn, cap[15:1]);
          chk("R3", "link_bd_ptr", link_bd_ptr, cap[31:16]);
          if (!link_busy) begin
            if (exp_q.size() == 0) chk("R10", "unexpected link", 1, 0);
            else chk("R10", "link order", cap, exp_q.pop_front());
            links++;
            phase = 3;
          end
        end
        3: begin
          chk("R5", "clear req", mem_req, 1);
          chk("R5", "clear dir", mem_we, 1);
          chk("R5", "clear addr", mem_addr, cfg_base + 32'(mptr));
          chk("R5", "clear data", mem_wdata, cap & 32'hFFFF_FFFE);
          chk("R5", "no link during clear", link_req, 0);
          if (mem_gnt) begin
            mem[mptr] = mem_wdata;
            mptr = (mptr + 1) % qsize;   // R6, R7
            phase = 0;
          end
        end
        default: begin
          chk("R8", "quiet during gap mem", mem_req, 0);
          chk("R8", "quiet during gap link", link_req, 0);
          gap_left--;
          if (gap_left == 0) phase = 0;
        end
      endcase
      if (host_left > 0 && mem[host_slot][0] == 1'b0) begin
        logic [31:0] w;
        w = {16'(sub_n * 13 + 16'h100), 15'(sub_n * 37 + 5), 1'b1};
        mem[host_slot] = w;
        exp_q.push_back(w);
        sub_n++;
        host_left--;
        host_slot = (host_slot + 1) % qsize;
      end
    end
  end

  task automatic run_case(logic [31:0] base, logic [4:0] lg, int eff, logic [15:0] gap,
                          bit busy, int n, string tag);
    int wait_cyc;
    @(posedge clk); #1;
    rst_n = 1'b0;
    cfg_base = base; cfg_size_log2 = lg; cfg_idle_gap = gap;
    busy_mode = busy; qsize = eff; host_slot = 0; links = 0;
    exp_q.delete();
    for (int i = 0; i < 16384; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (40) @(posedge clk);
    #1 host_left = n;
    wait_cyc = 0;
    while ((host_left > 0 || exp_q.size() > 0 || phase != 0) && wait_cyc < 40000) begin
      @(posedge clk); wait_cyc++;
    end
    repeat (10) @(posedge clk);
    chk("R10", {tag, " link count"}, links, n);
    for (int i = 0; i < eff; i++) chk("R5", {tag, " slot released"}, mem[i][0], 0);
    chk("R7", {tag, " pointer after wrap"}, mptr, n % eff);
  endtask

  initial begin
    // R1 R2 R3 R5 R6 R7 R8 R10: 64 slots, gap 3, many wraps
    run_case(32'h0000_1000, 5'd6, 64, 16'd3, 1'b0, 150, "A");
    // R4: scheduler refusals, 128 slots, gap 0
    run_case(32'h0000_2340, 5'd7, 128, 16'd0, 1'b1, 150, "B");
    // R9: exponent 3 clamps to 64 slots
    run_case(32'h0000_0040, 5'd3, 64, 16'd5, 1'b1, 80, "C");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule